// File: doc/BRIEF.md
# Divider Programming Register Front End

This block holds the divider settings of an integer-N frequency synthesizer and offers three ways of loading them. In serial mode a 20-bit word is shifted in on a slow serial clock. In parallel mode an 8-bit bus is written in three sections, each with its own write strobe. In direct mode the settings come straight from pins. The serial and parallel modes write a primary register. A copy strobe moves the primary contents into a secondary register, so the next channel can be loaded while the current one is in use. A select input then chooses which of the two registers drives the divider outputs, which makes fast frequency hopping possible.

A separate 8-bit control register holds power-down, immediate-load, data-output routing and monitor-disable controls. An active-low enable input gates these controls. In serial mode this register is loaded through a shift stage and takes effect only when its write line falls. In parallel mode it takes the bus value when its write line rises.

Every strobe, the serial clock and the data inputs arrive asynchronously. They pass through synchronizer flops clocked by a faster system clock, and each edge is then detected in that clock domain.

Top module: `pll_prog_regs`

## Requirements
- R1: After reset the primary, secondary and control registers are all zero. Outside direct mode, every divider output and every control output then reads 0 for either select value.
- R2: The mode inputs decode as follows: `bsel_direct`=1 is direct mode, `bsel_direct`=0 with `ssel_serial`=1 is serial mode, and both low is parallel mode. Strobes belonging to another mode have no effect: serial clocks in parallel mode, section strobes in serial mode, and any write in direct mode leave the registers unchanged.
- R3: In serial mode, with `swr` and `ewr` both low, each rising edge of `sclk` shifts `sdat` into the primary word, MSB first. After 20 bits, the bits from first to last are R[5:4], M[8:7], prescaler enable, M[6:0], R[3:0], A[3:0].
- R4: A rising edge of `swr` in serial mode, or of `hop` in serial or parallel mode, copies the primary word into the secondary word.
- R5: In parallel mode, a rising edge of `wr_top` loads `pdata[3:0]` into {R[5:4], M[8:7]}. A rising edge of `wr_mid` loads `pdata[7:0]` into {prescaler enable, M[6:0]}. A rising edge of `wr_low` loads `pdata[7:0]` into {R[3:0], A[3:0]}.
- R6: Outside direct mode, `fsel_pri`=1 drives the outputs from the primary word and `fsel_pri`=0 from the secondary word.
- R7: In serial mode, with `ewr` high and `swr` low, `sclk` rising edges shift `sdat` MSB first into an 8-bit stage. The control register takes the stage contents only on the falling edge of `ewr`, and its outputs do not change before that edge.
- R8: In parallel mode, a rising edge of `ewr` loads `pdata` into the control register.
- R9: The control outputs are 0 while `enh_en_n`=1. While it is 0, each output follows one bit of the control register: `pwr_down` bit 3, `cnt_load` bit 4, `dout_msel` bit 5, `dout_presc` bit 6 and `mon_off` bit 7. Bits 0 to 2 drive nothing.
- R10: In direct mode, R[3:0], M[6:0], A and the prescaler enable come from the pins for either select value, and R[5:4] and M[8:7] read 0. The stored primary and secondary words stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than every strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| bsel_direct | input | 1 | 1 selects direct mode |
| ssel_serial | input | 1 | Outside direct mode: 1 selects serial, 0 selects parallel |
| sclk | input | 1 | Serial shift clock |
| sdat | input | 1 | Serial data, MSB first |
| swr | input | 1 | Serial word write; its rising edge copies primary to secondary |
| ewr | input | 1 | Control register write / shift select |
| hop | input | 1 | Hop strobe; its rising edge copies primary to secondary |
| wr_top | input | 1 | Parallel strobe for the top nibble section |
| wr_mid | input | 1 | Parallel strobe for the middle byte section |
| wr_low | input | 1 | Parallel strobe for the low byte section |
| pdata | input | 8 | Parallel data bus |
| fsel_pri | input | 1 | 1 selects primary, 0 selects secondary |
| enh_en_n | input | 1 | Active-low enable for the control outputs |
| pin_r | input | 4 | Direct-mode R[3:0] |
| pin_m | input | 7 | Direct-mode M[6:0] |
| pin_a | input | 4 | Direct-mode A[3:0] |
| pin_pre_en | input | 1 | Direct-mode prescaler enable |
| r_div | output | 6 | Selected reference divider value |
| m_div | output | 9 | Selected main counter value |
| a_cnt | output | 4 | Selected swallow counter value |
| pre_en | output | 1 | Selected prescaler enable bit |
| pwr_down | output | 1 | Gated power-down control |
| cnt_load | output | 1 | Gated immediate counter load control |
| dout_msel | output | 1 | Gated route of modulus select to data out |
| dout_presc | output | 1 | Gated route of prescaler output to data out |
| mon_off | output | 1 | Gated disable of the divider monitor outputs |

## Verification
The bench uses the default synchronizer depth of two stages, which adds a fixed three-cycle delay from a strobe pin to its register update. The bench holds each strobe level for several system clocks, so every edge is seen exactly once. At this depth the bench can also reach all three load modes, the cross-mode ignore cases and the all-ones boundary word within a short run. The bench also checks the control register in the window between the end of serial shifting and the falling edge of its write line.

// File: rtl/pll_prog_pkg.sv
package pll_prog_pkg;

  // Fixed programming word format
  localparam int WORD_W   = 20;
  localparam int ENH_W    = 8;
  localparam int PDATA_W  = 8;
  localparam int R_W      = 6;
  localparam int M_W      = 9;
  localparam int A_W      = 4;
  localparam int R_PIN_W  = 4;
  localparam int M_PIN_W  = 7;
  localparam int TOP_W    = 4;

  // Control register bit positions
  localparam int ENH_PWR   = 3;
  localparam int ENH_LOAD  = 4;
  localparam int ENH_MSEL  = 5;
  localparam int ENH_PRESC = 6;
  localparam int ENH_MOFF  = 7;

  // Synchronized input bundle indices
  localparam int SI_SCLK  = 0;
  localparam int SI_SDAT  = 1;
  localparam int SI_SWR   = 2;
  localparam int SI_EWR   = 3;
  localparam int SI_HOP   = 4;
  localparam int SI_TOP   = 5;
  localparam int SI_MID   = 6;
  localparam int SI_LOW   = 7;
  localparam int SI_PDATA = 8;
  localparam int SI_W     = SI_PDATA + PDATA_W;

  typedef enum logic [1:0] {
    LOAD_PAR = 2'd0,
    LOAD_SER = 2'd1,
    LOAD_DIR = 2'd2
  } load_mode_e;

  typedef struct packed {
    logic [R_W-1:0] r;
    logic [M_W-1:0] m;
    logic [A_W-1:0] a;
    logic           pre_en;
  } div_set_t;

  function automatic load_mode_e decode_mode(input logic bsel, input logic ssel);
    if (bsel)      return LOAD_DIR;
    else if (ssel) return LOAD_SER;
    else           return LOAD_PAR;
  endfunction

  function automatic div_set_t unpack_word(input logic [WORD_W-1:0] w);
    div_set_t d;
    d.r      = {w[19:18], w[7:4]};
    d.m      = {w[17:16], w[14:8]};
    d.a      = w[3:0];
    d.pre_en = w[15];
    return d;
  endfunction

endpackage

// File: rtl/pll_prog_sync.sv
module pll_prog_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [W-1:0]             prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q[0] <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q <= '0;
        end else begin
          stage_q[0] <= async_i;
          for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[LAST];
  end

  assign level_o = stage_q[LAST];
  assign rise_o  = stage_q[LAST] & ~prev_q;
  assign fall_o  = ~stage_q[LAST] & prev_q;

endmodule

// File: rtl/pll_prog_word_regs.sv
module pll_prog_word_regs
  import pll_prog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  load_mode_e         mode,
  input  logic               sclk_rise,
  input  logic               sdat,
  input  logic               swr_lvl,
  input  logic               swr_rise,
  input  logic               ewr_lvl,
  input  logic               hop_rise,
  input  logic               top_rise,
  input  logic               mid_rise,
  input  logic               low_rise,
  input  logic [PDATA_W-1:0] pdata,
  output logic [WORD_W-1:0]  prim_o,
  output logic [WORD_W-1:0]  sec_o
);

  logic [WORD_W-1:0] prim_q, prim_d;
  logic [WORD_W-1:0] sec_q;
  logic              prim_en, sec_en;
  logic              shift_en;

  assign shift_en = (mode == LOAD_SER) && sclk_rise && !swr_lvl && !ewr_lvl;

  // primary next state
  always_comb begin
    prim_d  = prim_q;
    prim_en = 1'b0;
    if (mode == LOAD_SER) begin
      if (shift_en) begin
        prim_d  = {prim_q[WORD_W-2:0], sdat};
        prim_en = 1'b1;
      end
    end else if (mode == LOAD_PAR) begin
      if (top_rise) begin
        prim_d[WORD_W-1 -: TOP_W] = pdata[TOP_W-1:0];
        prim_en = 1'b1;
      end
      if (mid_rise) begin
        prim_d[2*PDATA_W-1 -: PDATA_W] = pdata;
        prim_en = 1'b1;
      end
      if (low_rise) begin
        prim_d[PDATA_W-1:0] = pdata;
        prim_en = 1'b1;
      end
    end
  end

  // secondary copy enable
  always_comb begin
    sec_en = 1'b0;
    if (mode == LOAD_SER && swr_rise) sec_en = 1'b1;
    if (mode != LOAD_DIR && hop_rise) sec_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prim_q <= '0;
    else if (prim_en) prim_q <= prim_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sec_q <= '0;
    else if (sec_en) sec_q <= prim_q;
  end

  assign prim_o = prim_q;
  assign sec_o  = sec_q;

endmodule

// File: rtl/pll_prog_enh_reg.sv
module pll_prog_enh_reg
  import pll_prog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  load_mode_e         mode,
  input  logic               sclk_rise,
  input  logic               sdat,
  input  logic               swr_lvl,
  input  logic               ewr_lvl,
  input  logic               ewr_rise,
  input  logic               ewr_fall,
  input  logic [PDATA_W-1:0] pdata,
  output logic [ENH_W-1:0]   enh_o
);

  logic [ENH_W-1:0] stage_q, stage_d;
  logic [ENH_W-1:0] enh_q, enh_d;
  logic             stage_en, enh_en;

  // shift stage next state
  always_comb begin
    stage_en = (mode == LOAD_SER) && sclk_rise && ewr_lvl && !swr_lvl;
    stage_d  = {stage_q[ENH_W-2:0], sdat};
  end

  // control register next state
  always_comb begin
    enh_en = 1'b0;
    enh_d  = enh_q;
    if (mode == LOAD_SER && ewr_fall) begin
      enh_en = 1'b1;
      enh_d  = stage_q;
    end else if (mode == LOAD_PAR && ewr_rise) begin
      enh_en = 1'b1;
      enh_d  = pdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      enh_q <= '0;
    else if (enh_en) enh_q <= enh_d;
  end

  assign enh_o = enh_q;

endmodule

// File: rtl/pll_prog_regs.sv
module pll_prog_regs
  import pll_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bsel_direct,
  input  logic               ssel_serial,
  input  logic               sclk,
  input  logic               sdat,
  input  logic               swr,
  input  logic               ewr,
  input  logic               hop,
  input  logic               wr_top,
  input  logic               wr_mid,
  input  logic               wr_low,
  input  logic [PDATA_W-1:0] pdata,
  input  logic               fsel_pri,
  input  logic               enh_en_n,
  input  logic [R_PIN_W-1:0] pin_r,
  input  logic [M_PIN_W-1:0] pin_m,
  input  logic [A_W-1:0]     pin_a,
  input  logic               pin_pre_en,
  output logic [R_W-1:0]     r_div,
  output logic [M_W-1:0]     m_div,
  output logic [A_W-1:0]     a_cnt,
  output logic               pre_en,
  output logic               pwr_down,
  output logic               cnt_load,
  output logic               dout_msel,
  output logic               dout_presc,
  output logic               mon_off
);

  localparam int RST_STAGES = 2;

  // reset: asynchronous assert, synchronous release
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[RST_STAGES-1];

  // input synchronization
  logic [SI_W-1:0] async_bus, sync_lvl, sync_rise, sync_fall;

  assign async_bus = {pdata, wr_low, wr_mid, wr_top, hop, ewr, swr, sdat, sclk};

  pll_prog_sync #(.W(SI_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .async_i (async_bus),
    .level_o (sync_lvl),
    .rise_o  (sync_rise),
    .fall_o  (sync_fall)
  );

  load_mode_e mode;
  assign mode = decode_mode(bsel_direct, ssel_serial);

  logic [WORD_W-1:0] prim_q, sec_q;
  logic [ENH_W-1:0]  enh_q;

  pll_prog_word_regs u_word (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .mode      (mode),
    .sclk_rise (sync_rise[SI_SCLK]),
    .sdat      (sync_lvl[SI_SDAT]),
    .swr_lvl   (sync_lvl[SI_SWR]),
    .swr_rise  (sync_rise[SI_SWR]),
    .ewr_lvl   (sync_lvl[SI_EWR]),
    .hop_rise  (sync_rise[SI_HOP]),
    .top_rise  (sync_rise[SI_TOP]),
    .mid_rise  (sync_rise[SI_MID]),
    .low_rise  (sync_rise[SI_LOW]),
    .pdata     (sync_lvl[SI_PDATA +: PDATA_W]),
    .prim_o    (prim_q),
    .sec_o     (sec_q)
  );

  pll_prog_enh_reg u_enh (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .mode      (mode),
    .sclk_rise (sync_rise[SI_SCLK]),
    .sdat      (sync_lvl[SI_SDAT]),
    .swr_lvl   (sync_lvl[SI_SWR]),
    .ewr_lvl   (sync_lvl[SI_EWR]),
    .ewr_rise  (sync_rise[SI_EWR]),
    .ewr_fall  (sync_fall[SI_EWR]),
    .pdata     (sync_lvl[SI_PDATA +: PDATA_W]),
    .enh_o     (enh_q)
  );

  // divider output selection
  div_set_t sel_set;

  always_comb begin
    if (mode == LOAD_DIR) begin
      sel_set.r      = {{(R_W-R_PIN_W){1'b0}}, pin_r};
      sel_set.m      = {{(M_W-M_PIN_W){1'b0}}, pin_m};
      sel_set.a      = pin_a;
      sel_set.pre_en = pin_pre_en;
    end else if (fsel_pri) begin
      sel_set = unpack_word(prim_q);
    end else begin
      sel_set = unpack_word(sec_q);
    end
  end

  assign r_div  = sel_set.r;
  assign m_div  = sel_set.m;
  assign a_cnt  = sel_set.a;
  assign pre_en = sel_set.pre_en;

  // gated control outputs
  logic enh_gate;
  assign enh_gate   = ~enh_en_n;
  assign pwr_down   = enh_gate & enh_q[ENH_PWR];
  assign cnt_load   = enh_gate & enh_q[ENH_LOAD];
  assign dout_msel  = enh_gate & enh_q[ENH_MSEL];
  assign dout_presc = enh_gate & enh_q[ENH_PRESC];
  assign mon_off    = enh_gate & enh_q[ENH_MOFF];

endmodule

// File: rtl/pll_prog_regs_chk.sv
module pll_prog_regs_chk
  import pll_prog_pkg::*;
(
  input logic               clk,
  input logic               rst_q_n,
  input logic               bsel_direct,
  input logic               enh_en_n,
  input logic [R_PIN_W-1:0] pin_r,
  input logic [M_PIN_W-1:0] pin_m,
  input logic [R_W-1:0]     r_div,
  input logic [M_W-1:0]     m_div,
  input logic               pwr_down,
  input logic               cnt_load,
  input logic               dout_msel,
  input logic               dout_presc,
  input logic               mon_off,
  input logic [WORD_W-1:0]  prim_q,
  input logic [WORD_W-1:0]  sec_q,
  input logic [ENH_W-1:0]   enh_q
);

  AST_SEC_FROM_PRIMARY: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$stable(sec_q) |-> sec_q == $past(prim_q)); // R4

  AST_CTRL_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_q_n)
    enh_en_n |-> !(pwr_down || cnt_load || dout_msel || dout_presc || mon_off)); // R9

  AST_DIRECT_FROM_PINS: assert property (@(posedge clk) disable iff (!rst_q_n)
    bsel_direct |-> (r_div == {2'b00, pin_r}) && (m_div == {2'b00, pin_m})); // R10

  AST_PRIMARY_HOLD_DIRECT: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(bsel_direct) |-> $stable(prim_q)); // R10

  AST_SECONDARY_HOLD_DIRECT: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(bsel_direct) |-> $stable(sec_q)); // R10

  AST_CTRL_HOLD_DIRECT: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(bsel_direct) |-> $stable(enh_q)); // R2

endmodule

bind pll_prog_regs pll_prog_regs_chk u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .bsel_direct (bsel_direct),
  .enh_en_n    (enh_en_n),
  .pin_r       (pin_r),
  .pin_m       (pin_m),
  .r_div       (r_div),
  .m_div       (m_div),
  .pwr_down    (pwr_down),
  .cnt_load    (cnt_load),
  .dout_msel   (dout_msel),
  .dout_presc  (dout_presc),
  .mon_off     (mon_off),
  .prim_q      (prim_q),
  .sec_q       (sec_q),
  .enh_q       (enh_q)
);

// File: tb/pll_prog_regs_test.sv
module pll_prog_regs_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bsel_direct, ssel_serial, sclk, sdat, swr, ewr, hop;
  logic       wr_top, wr_mid, wr_low, fsel_pri, enh_en_n, pin_pre_en;
  logic [7:0] pdata;
  logic [3:0] pin_r, pin_a;
  logic [6:0] pin_m;
  logic [5:0] r_div;
  logic [8:0] m_div;
  logic [3:0] a_cnt;
  logic       pre_en, pwr_down, cnt_load, dout_msel, dout_presc, mon_off;

  always #2 clk = ~clk;

  pll_prog_regs uut (
    .clk(clk), .rst_n(rst_n), .bsel_direct(bsel_direct), .ssel_serial(ssel_serial),
    .sclk(sclk), .sdat(sdat), .swr(swr), .ewr(ewr), .hop(hop),
    .wr_top(wr_top), .wr_mid(wr_mid), .wr_low(wr_low), .pdata(pdata),
    .fsel_pri(fsel_pri), .enh_en_n(enh_en_n), .pin_r(pin_r), .pin_m(pin_m),
    .pin_a(pin_a), .pin_pre_en(pin_pre_en), .r_div(r_div), .m_div(m_div),
    .a_cnt(a_cnt), .pre_en(pre_en), .pwr_down(pwr_down), .cnt_load(cnt_load),
    .dout_msel(dout_msel), .dout_presc(dout_presc), .mon_off(mon_off)
  );

  logic [24:0] obs;
  assign obs = {r_div, m_div, a_cnt, pre_en, pwr_down, cnt_load, dout_msel, dout_presc, mon_off};

  typedef struct {
    logic [24:0] v;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  event chk_ev;
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // reference state kept from the requirements
  logic [19:0] m_pri, m_sec;
  logic [7:0]  m_enh;

  // R3/R5/R9 field layout
  function automatic logic [24:0] exp_word(logic [19:0] w, logic [7:0] e, logic en_n);
    logic g;
    g = ~en_n;
    return {w[19:18], w[7:4], w[17:16], w[14:8], w[3:0], w[15],
            g & e[3], g & e[4], g & e[5], g & e[6], g & e[7]};
  endfunction

  // R10 direct pin layout
  function automatic logic [24:0] exp_pins(logic [7:0] e, logic en_n);
    logic g;
    g = ~en_n;
    return {2'b00, pin_r, 2'b00, pin_m, pin_a, pin_pre_en,
            g & e[3], g & e[4], g & e[5], g & e[6], g & e[7]};
  endfunction

  // monitor: compares outputs against queued expectations
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_run++;
        if (obs !== e.v) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", e.tag, obs, e.v);
        end
      end
    end
  end

  task automatic push_exp(input logic [24:0] v, input string tag);
    exp_t e;
    repeat (6) @(posedge clk);
    @(negedge clk);
    e.v = v;
    e.tag = tag;
    sb_q.push_back(e);
    -> chk_ev;
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: swr = 1'b1; 1: ewr = 1'b1; 2: hop = 1'b1;
      3: wr_top = 1'b1; 4: wr_mid = 1'b1; default: wr_low = 1'b1;
    endcase
    repeat (4) @(negedge clk);
    case (which)
      0: swr = 1'b0; 1: ewr = 1'b0; 2: hop = 1'b0;
      3: wr_top = 1'b0; 4: wr_mid = 1'b0; default: wr_low = 1'b0;
    endcase
    repeat (4) @(negedge clk);
  endtask

  task automatic ser_bits(input logic [19:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      sdat = w[i];
      sclk = 1'b0;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_fsel(input logic v);
    @(negedge clk);
    fsel_pri = v;
  endtask

  initial begin
    rst_n = 1'b0; bsel_direct = 0; ssel_serial = 0; sclk = 0; sdat = 0;
    swr = 0; ewr = 0; hop = 0; wr_top = 0; wr_mid = 0; wr_low = 0; pdata = '0;
    fsel_pri = 1; enh_en_n = 0; pin_r = '0; pin_m = '0; pin_a = '0; pin_pre_en = 0;
    m_pri = '0; m_sec = '0; m_enh = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    push_exp(exp_word(20'h0, 8'h0, 0), "R1 reset primary");
    set_fsel(0);
    push_exp(exp_word(20'h0, 8'h0, 0), "R1 reset secondary");

    // serial word into primary
    @(negedge clk); ssel_serial = 1; fsel_pri = 1;
    ser_bits(20'hB6E5D, 20); m_pri = 20'hB6E5D;
    push_exp(exp_word(m_pri, m_enh, 0), "R3 serial word");
    set_fsel(0);
    push_exp(exp_word(m_sec, m_enh, 0), "R6 secondary selected");
    strobe(0); m_sec = m_pri;
    push_exp(exp_word(m_sec, m_enh, 0), "R4 serial write copy");

    // serial control register
    set_fsel(1);
    @(negedge clk); ewr = 1'b1;
    repeat (4) @(negedge clk);
    ser_bits({12'h0, 8'hF8}, 8);
    push_exp(exp_word(m_pri, m_enh, 0), "R7 no effect before fall");
    @(negedge clk); ewr = 1'b0; m_enh = 8'hF8;
    push_exp(exp_word(m_pri, m_enh, 0), "R7 capture on fall");
    @(negedge clk); enh_en_n = 1'b1;
    push_exp(exp_word(m_pri, m_enh, 1), "R9 gated off");
    @(negedge clk); enh_en_n = 1'b0;

    // parallel sections
    @(negedge clk); ssel_serial = 0;
    pdata = 8'hF9; strobe(3);
    pdata = 8'h3C; strobe(4);
    pdata = 8'hA7; strobe(5);
    m_pri = {4'h9, 8'h3C, 8'hA7};
    push_exp(exp_word(m_pri, m_enh, 0), "R5 parallel sections");
    set_fsel(0);
    push_exp(exp_word(m_sec, m_enh, 0), "R6 secondary kept");
    strobe(2); m_sec = m_pri;
    push_exp(exp_word(m_sec, m_enh, 0), "R4 hop copy");
    set_fsel(1);
    @(negedge clk); pdata = 8'h28;
    strobe(1); m_enh = 8'h28;
    push_exp(exp_word(m_pri, m_enh, 0), "R8 parallel control write");

    // cross-mode strobes ignored
    ser_bits(20'h12345, 20);
    strobe(0);
    push_exp(exp_word(m_pri, m_enh, 0), "R2 serial ignored in parallel");
    @(negedge clk); ssel_serial = 1; pdata = 8'h55;
    strobe(4); strobe(5); strobe(3);
    push_exp(exp_word(m_pri, m_enh, 0), "R2 sections ignored in serial");

    // direct mode
    @(negedge clk); bsel_direct = 1; pin_r = 4'hB; pin_m = 7'h5A; pin_a = 4'h6; pin_pre_en = 1;
    push_exp(exp_pins(m_enh, 0), "R10 direct pins primary sel");
    set_fsel(0);
    push_exp(exp_pins(m_enh, 0), "R10 direct pins secondary sel");
    @(negedge clk); pdata = 8'h00;
    strobe(4); strobe(2); strobe(0);
    ser_bits(20'h00000, 4);
    @(negedge clk); bsel_direct = 0; ssel_serial = 0; fsel_pri = 1;
    push_exp(exp_word(m_pri, m_enh, 0), "R10 primary unchanged by direct");
    set_fsel(0);
    push_exp(exp_word(m_sec, m_enh, 0), "R10 secondary unchanged by direct");

    // all-ones boundary word
    @(negedge clk); ssel_serial = 1; fsel_pri = 1;
    ser_bits(20'hFFFFF, 20); m_pri = 20'hFFFFF;
    push_exp(exp_word(m_pri, m_enh, 0), "R3 all ones word");

    #1;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule